// File: doc/BRIEF.md
# Page Permission Fault Checker

This block judges one translated memory access in the same cycle it is presented. It takes the outcome of a page-table walk (a found flag and the leaf page-table entry), the kind of access (instruction fetch, data load or data store), the current privilege mode, and the two status bits that relax load permission ("make executable readable") and allow supervisor access to user pages. It reports whether the access may proceed. On a refusal it produces the supervisor exception cause for a page fault of the right kind, and a trap value that carries the faulting virtual address.

The checker is purely combinational and has no clock or reset. The structure is a small decision chain of three named stages. The WALK stage checks that an entry exists and is valid. The RIGHTS stage checks the read, write and execute bits against the access. The OWNER stage checks the user bit against the privilege mode. Each stage either passes to the next or ends the chain in FAULT. A pass through all three ends in GRANT. The CAUSE stage maps the access type to a cause code whenever the chain ends in FAULT. The walk itself and the writing of cause and trap value into control registers are done elsewhere.

Entry bit positions are V = bit 0, R = bit 1, W = bit 2, X = bit 3 and U = bit 4. The access code is 0 for fetch, 1 for load, 2 for store and 3 for reserved. The privilege code is 0 for user, 1 for supervisor and 3 for machine, with 2 reserved.

Top module: `pte_perm_check`

## Requirements
- R1: When `found_i` is 0, the access faults, whatever the value of `pte_i`.
- R2: When the entry's V bit (bit 0) is 0, the access faults.
- R3: A fetch (access 0) faults unless X (bit 3) is 1. A store (access 2) faults unless W (bit 2) is 1. The reserved access code 3 is judged as a store.
- R4: With `mxr_i` = 0, a load (access 1) faults unless R (bit 1) is 1. With `mxr_i` = 1, a load is granted when R or X is 1.
- R5: In supervisor mode (priv 1) with `sum_i` = 0, an access to an entry with U (bit 4) = 1 faults. With `sum_i` = 1, the U bit does not block supervisor access.
- R6: In user mode (priv 0), an access to an entry with U = 0 faults. In machine mode (priv 3) and in the reserved mode 2, the U bit is not checked.
- R7: On a fault, `cause_o` is 12 for a fetch, 13 for a load and 15 for a store or the reserved access code.
- R8: On a fault, `tval_o` equals `vaddr_i`.
- R9: `fault_o` is always the inverse of `allow_o`. When the access is allowed, both `cause_o` and `tval_o` are 0.
- R10: `mxr_i` has no effect on fetches or stores. `sum_i` has no effect outside supervisor mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| found_i | input | 1 | Walk located a leaf entry |
| pte_i | input | 32 | Leaf page-table entry |
| access_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 reserved |
| priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| mxr_i | input | 1 | Loads may use executable pages |
| sum_i | input | 1 | Supervisor may touch user pages |
| vaddr_i | input | 32 | Virtual address of the access |
| allow_o | output | 1 | Access permitted |
| fault_o | output | 1 | Access refused |
| cause_o | output | 32 | Page-fault cause code, 0 when allowed |
| tval_o | output | 32 | Faulting virtual address, 0 when allowed |

## Verification
The rights rule and the ownership rule can both refuse the same access in one evaluation. One example is a supervisor load without SUM from a user page that has neither R nor X. Another is a user store to a supervisor page without W. Both must still yield exactly one fault with a single cause code chosen only by the access type. Directed vectors set up these double violations, and the random stream hits them often because every entry bit and status bit is drawn independently. A bench reference function recomputes the allow flag, cause and trap value for each vector and compares them.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_RSVD  = 2'd2,
        PRV_MACH  = 2'd3
    } prv_e;

    // decision chain stages
    typedef enum logic [2:0] {
        ST_WALK,
        ST_RIGHTS,
        ST_OWNER,
        ST_GRANT,
        ST_FAULT
    } chk_e;

    localparam int BIT_V = 0;
    localparam int BIT_R = 1;
    localparam int BIT_W = 2;
    localparam int BIT_X = 3;
    localparam int BIT_U = 4;

    localparam int CODE_FETCH_PF = 12;
    localparam int CODE_LOAD_PF  = 13;
    localparam int CODE_STORE_PF = 15;

endpackage

// File: rtl/pfc_rights.sv
module pfc_rights
    import pfc_pkg::*;
(
    input  logic       r_i,
    input  logic       w_i,
    input  logic       x_i,
    input  acc_e       acc_i,
    input  logic       mxr_i,
    output logic       pass_o
);

    always_comb begin
        unique case (acc_i)
            ACC_FETCH: pass_o = x_i;
            ACC_LOAD:  pass_o = r_i | (mxr_i & x_i);
            ACC_STORE,
            ACC_RSVD:  pass_o = w_i;
            default:   pass_o = 1'b0;
        endcase
    end

    // an execute-only page is never readable without the relax bit
    always_comb begin
        p_xonly_load_blocked_r4: assert (!(acc_i == ACC_LOAD && !r_i && !mxr_i) || !pass_o)
            else $error("p_xonly_load_blocked_r4");
        p_store_needs_w_r3: assert (!((acc_i == ACC_STORE || acc_i == ACC_RSVD) && pass_o) || w_i)
            else $error("p_store_needs_w_r3");
    end

endmodule

// File: rtl/pfc_owner.sv
module pfc_owner
    import pfc_pkg::*;
(
    input  logic u_i,
    input  prv_e prv_i,
    input  logic sum_i,
    output logic pass_o
);

    always_comb begin
        unique case (prv_i)
            PRV_USER:  pass_o = u_i;
            PRV_SUPER: pass_o = !u_i || sum_i;
            PRV_RSVD,
            PRV_MACH:  pass_o = 1'b1;
            default:   pass_o = 1'b0;
        endcase
    end

    always_comb begin
        p_user_page_only_r6: assert (!(prv_i == PRV_USER && !u_i) || !pass_o)
            else $error("p_user_page_only_r6");
    end

endmodule

// File: rtl/pfc_cause.sv
module pfc_cause
    import pfc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  acc_e            acc_i,
    input  logic            fault_i,
    output logic [XLEN-1:0] cause_o
);

    logic [XLEN-1:0] code;

    always_comb begin
        unique case (acc_i)
            ACC_FETCH: code = XLEN'(CODE_FETCH_PF);
            ACC_LOAD:  code = XLEN'(CODE_LOAD_PF);
            ACC_STORE,
            ACC_RSVD:  code = XLEN'(CODE_STORE_PF);
            default:   code = '0;
        endcase
        cause_o = fault_i ? code : '0;
    end

endmodule

// File: rtl/pte_perm_check.sv
module pte_perm_check
    import pfc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int PTE_W = 32
) (
    input  logic             found_i,
    input  logic [PTE_W-1:0] pte_i,
    input  logic [1:0]       access_i,
    input  logic [1:0]       priv_i,
    input  logic             mxr_i,
    input  logic             sum_i,
    input  logic [XLEN-1:0]  vaddr_i,
    output logic             allow_o,
    output logic             fault_o,
    output logic [XLEN-1:0]  cause_o,
    output logic [XLEN-1:0]  tval_o
);

    acc_e acc;
    prv_e prv;
    logic rights_ok;
    logic owner_ok;
    chk_e end_st;

    assign acc = acc_e'(access_i);
    assign prv = prv_e'(priv_i);

    pfc_rights u_rights (
        .r_i    (pte_i[BIT_R]),
        .w_i    (pte_i[BIT_W]),
        .x_i    (pte_i[BIT_X]),
        .acc_i  (acc),
        .mxr_i  (mxr_i),
        .pass_o (rights_ok)
    );

    pfc_owner u_owner (
        .u_i    (pte_i[BIT_U]),
        .prv_i  (prv),
        .sum_i  (sum_i),
        .pass_o (owner_ok)
    );

    // walk the decision chain to its terminal stage
    always_comb begin
        chk_e st;
        st = ST_WALK;
        for (int step = 0; step < 3; step++) begin
            unique case (st)
                ST_WALK:   st = (found_i && pte_i[BIT_V]) ? ST_RIGHTS : ST_FAULT;
                ST_RIGHTS: st = rights_ok ? ST_OWNER : ST_FAULT;
                ST_OWNER:  st = owner_ok ? ST_GRANT : ST_FAULT;
                ST_GRANT:  st = ST_GRANT;
                ST_FAULT:  st = ST_FAULT;
                default:   st = ST_FAULT;
            endcase
        end
        end_st = st;
    end

    pfc_cause #(.XLEN(XLEN)) u_cause (
        .acc_i   (acc),
        .fault_i (fault_o),
        .cause_o (cause_o)
    );

    always_comb begin
        allow_o = (end_st == ST_GRANT);
        fault_o = (end_st == ST_FAULT);
        tval_o  = fault_o ? vaddr_i : '0;
    end

    always_comb begin
        p_missing_faults_r1: assert (found_i || fault_o)
            else $error("p_missing_faults_r1");
        p_invalid_faults_r2: assert (pte_i[BIT_V] || fault_o)
            else $error("p_invalid_faults_r2");
        p_sum_blocks_r5: assert (!(priv_i == 2'd1 && !sum_i && pte_i[BIT_U]) || fault_o)
            else $error("p_sum_blocks_r5");
        p_cause_known_r7: assert (!fault_o || cause_o == 32'd12 || cause_o == 32'd13 || cause_o == 32'd15)
            else $error("p_cause_known_r7");
        p_tval_addr_r8: assert (!fault_o || tval_o == vaddr_i)
            else $error("p_tval_addr_r8");
        p_exclusive_r9: assert (allow_o != fault_o)
            else $error("p_exclusive_r9");
        p_clean_grant_r9: assert (!allow_o || (cause_o == '0 && tval_o == '0))
            else $error("p_clean_grant_r9");
    end

endmodule

// File: tb/sim_pte_perm_check.sv
module sim_pte_perm_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        found_i = 1'b0;
    logic [31:0] pte_i = '0;
    logic [1:0]  access_i = '0;
    logic [1:0]  priv_i = '0;
    logic        mxr_i = 1'b0;
    logic        sum_i = 1'b0;
    logic [31:0] vaddr_i = 32'h1234_5000;
    logic        allow_o, fault_o;
    logic [31:0] cause_o, tval_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pte_perm_check u0 (
        .found_i(found_i), .pte_i(pte_i), .access_i(access_i), .priv_i(priv_i),
        .mxr_i(mxr_i), .sum_i(sum_i), .vaddr_i(vaddr_i),
        .allow_o(allow_o), .fault_o(fault_o), .cause_o(cause_o), .tval_o(tval_o)
    );

    function automatic bit ref_allow(bit f, logic [31:0] p, logic [1:0] a,
                                     logic [1:0] pv, bit mx, bit sm);
        bit ok;
        ok = f && p[0];
        case (a)
            2'd0: ok = ok && p[3];
            2'd1: ok = ok && (p[1] || (mx && p[3]));
            default: ok = ok && p[2];
        endcase
        if (pv == 2'd0) ok = ok && p[4];
        if (pv == 2'd1 && !sm) ok = ok && !p[4];
        return ok;
    endfunction

    function automatic logic [31:0] ref_cause(logic [1:0] a);
        return (a == 2'd0) ? 32'd12 : (a == 2'd1) ? 32'd13 : 32'd15;
    endfunction

    task automatic check(string tag);
        bit ok;
        logic [31:0] ec, et;
        ok = ref_allow(found_i, pte_i, access_i, priv_i, mxr_i, sum_i);
        ec = ok ? 32'd0 : ref_cause(access_i);
        et = ok ? 32'd0 : vaddr_i;
        n_cmp++;
        if (allow_o !== ok || fault_o !== !ok || cause_o !== ec || tval_o !== et) begin
            n_bad++;
            $display("FAIL %s: allow=%0b fault=%0b cause=%0d tval=%h expected allow=%0b cause=%0d tval=%h",
                     tag, allow_o, fault_o, cause_o, tval_o, ok, ec, et);
        end
    endtask

    task automatic apply(string tag, bit f, logic [31:0] p, logic [1:0] a,
                         logic [1:0] pv, bit mx, bit sm, logic [31:0] va);
        @(negedge clk);
        found_i = f; pte_i = p; access_i = a; priv_i = pv;
        mxr_i = mx; sum_i = sm; vaddr_i = va;
        #5;
        check(tag);
    endtask

    task automatic expect_allow(string tag, bit want);
        n_cmp++;
        if (allow_o !== want) begin
            n_bad++;
            $display("FAIL %s: allow=%0b expected %0b", tag, allow_o, want);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [31:0] rv;
        seed = 32'd20240611;
        rv = $urandom(seed);
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #5;
        // reset state: nothing found, must fault as fetch
        check("R1 reset state");

        // PTE bits: V=1 R=2 W=4 X=8 U=16
        apply("R1 missing entry", 1'b0, 32'h1F, 2'd1, 2'd3, 1'b0, 1'b0, 32'hA000_0004);
        apply("R2 invalid entry", 1'b1, 32'h1E, 2'd0, 2'd3, 1'b0, 1'b0, 32'hA000_0008);
        apply("R3 fetch no X",    1'b1, 32'h07, 2'd0, 2'd3, 1'b0, 1'b0, 32'h0000_1000);
        apply("R3 fetch X",       1'b1, 32'h09, 2'd0, 2'd3, 1'b0, 1'b0, 32'h0000_1000);
        expect_allow("R3 fetch X allowed", 1'b1);
        apply("R3 store no W",    1'b1, 32'h0B, 2'd2, 2'd3, 1'b0, 1'b0, 32'h0000_2000);
        apply("R3 reserved access no W", 1'b1, 32'h0B, 2'd3, 2'd3, 1'b0, 1'b0, 32'h0000_2004);
        apply("R3 reserved access W", 1'b1, 32'h05, 2'd3, 2'd3, 1'b0, 1'b0, 32'h0000_2008);
        expect_allow("R3 reserved access W allowed", 1'b1);
        apply("R4 xonly load no mxr", 1'b1, 32'h09, 2'd1, 2'd3, 1'b0, 1'b0, 32'h0000_3000);
        expect_allow("R4 xonly load blocked", 1'b0);
        apply("R4 xonly load mxr",    1'b1, 32'h09, 2'd1, 2'd3, 1'b1, 1'b0, 32'h0000_3000);
        expect_allow("R4 xonly load granted", 1'b1);
        apply("R4 no R no X mxr",     1'b1, 32'h05, 2'd1, 2'd3, 1'b1, 1'b0, 32'h0000_3004);
        apply("R5 super user page",   1'b1, 32'h13, 2'd1, 2'd1, 1'b0, 1'b0, 32'h0000_4000);
        expect_allow("R5 blocked without sum", 1'b0);
        apply("R5 super user page sum", 1'b1, 32'h13, 2'd1, 2'd1, 1'b0, 1'b1, 32'h0000_4000);
        expect_allow("R5 granted with sum", 1'b1);
        apply("R6 user super page",   1'b1, 32'h03, 2'd1, 2'd0, 1'b0, 1'b1, 32'h0000_5000);
        expect_allow("R6 user blocked", 1'b0);
        apply("R6 machine user page", 1'b1, 32'h13, 2'd1, 2'd3, 1'b0, 1'b0, 32'h0000_5004);
        expect_allow("R6 machine ignores U", 1'b1);
        apply("R6 reserved priv",     1'b1, 32'h13, 2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_5008);
        apply("R7 load cause",        1'b0, 32'h00, 2'd1, 2'd1, 1'b0, 1'b0, 32'hFFFF_FFFC);
        apply("R7 fetch cause",       1'b0, 32'h00, 2'd0, 2'd1, 1'b0, 1'b0, 32'h8000_0000);
        apply("R8 tval top addr",     1'b1, 32'h00, 2'd2, 2'd1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        apply("R9 clean grant",       1'b1, 32'h1F, 2'd2, 2'd0, 1'b1, 1'b1, 32'hDEAD_BEEF);
        apply("R10 mxr no effect on store", 1'b1, 32'h09, 2'd2, 2'd3, 1'b1, 1'b0, 32'h0000_6000);
        expect_allow("R10 store stays blocked", 1'b0);
        apply("R10 sum no effect in user", 1'b1, 32'h0F, 2'd0, 2'd0, 1'b0, 1'b1, 32'h0000_6004);
        expect_allow("R10 user stays blocked", 1'b0);
        // double violation: rights and owner both fail
        apply("R7 double violation", 1'b1, 32'h15, 2'd1, 2'd1, 1'b0, 1'b0, 32'h0000_7000);
        apply("R7 double violation user", 1'b1, 32'h03, 2'd2, 2'd0, 1'b0, 1'b0, 32'h0000_7004);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] p;
            p = $urandom;
            p[0] = ($urandom % 8) != 0;
            apply("R7 R8 R9 random", ($urandom % 8) != 0, p, 2'($urandom), 2'($urandom),
                  1'($urandom), 1'($urandom), $urandom);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule